// File: doc/BRIEF.md
# Dual-Rank Bus Register with Serial Shifter

This block stores one data word in two ranks. The upper rank (A) faces a shared bidirectional bus port, and the lower rank (B) is a serial shift register. The bus port is split into an input word, an output word and an output-enable flag, so that a pad ring or a bus fabric can form the tri-state driver. Five active-low controls decide what happens at each rising clock edge. A can load from the port, B can be copied up into A, A can be copied down into B, and B can shift by one place. When the port load and the up-copy are both requested, A takes the bitwise OR of the port and B. Operations that do not conflict run together on one edge, and each one sees the values the registers held before that edge.

Requesting the up-copy and the down-copy together is a synchronous clear. If the port load is also requested, A loads the port word and only B clears. The serial input enters B at bit 0. The serial output is the top bit of B. Blocks are chained into a wider word by wiring one block's serial output to the next block's serial input and sharing every control line. The output enable only affects the port flag and never stops a register operation.

Top module: `dual_rank_shreg`

## Requirements
- R1: While `rst` is high at a clock edge, A and B both become zero, so `port_out` and `ser_out` read 0 after reset.
- R2: With `ld_n`=0 and `up_n`=1 at an edge, A takes `port_in`, and `port_out` shows it after that edge.
- R3: With `ld_n`=1 and `up_n`=1, A keeps its value. With `dn_n`=1, `sh_n`=1 and no clear, B keeps its value.
- R4: With `dn_n`=0 and `up_n`=1, B takes the value A held before the edge.
- R5: With `up_n`=0, `dn_n`=1 and `ld_n`=1, A takes the value B held before the edge.
- R6: With `up_n`=0, `dn_n`=1 and `ld_n`=0, A takes `port_in | B`, merged bit by bit, using the pre-edge B.
- R7: With `sh_n`=0, `dn_n`=1 and no clear, B becomes {B[W-2:0], `ser_in`}, and `ser_out` always equals B[W-1].
- R8: A load into A and a down-copy share an edge, a load and a shift share an edge, and an up-copy and a shift share an edge. Every operation uses the pre-edge register values.
- R9: With `up_n`=0, `dn_n`=0 and `ld_n`=1, both A and B become zero, and `sh_n` is ignored.
- R10: With `up_n`=0, `dn_n`=0 and `ld_n`=0, A takes `port_in` and B becomes zero.
- R11: With `dn_n`=0, `up_n`=1 and `sh_n`=0, the down-copy wins and B takes A with no shift.
- R12: `port_oe` is 1 exactly when `oe_n`=0 and `ld_n`=1. `oe_n` never changes any register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low port output enable |
| ld_n | input | 1 | Active-low port load into A (also masks the port driver) |
| up_n | input | 1 | Active-low copy B up into A |
| dn_n | input | 1 | Active-low copy A down into B |
| sh_n | input | 1 | Active-low serial shift of B |
| port_in | input | WIDTH | Word seen on the shared bus port |
| port_out | output | WIDTH | Contents of A, to be driven onto the port |
| port_oe | output | 1 | Drive enable for the port |
| ser_in | input | 1 | Serial data into B bit 0 |
| ser_out | output | 1 | Top bit of B, for chaining |

## Verification
The bench stresses the pairs of operations that share an edge. A design that read post-edge values would produce a swapped or duplicated word when load meets down-copy, or when up-copy meets shift. It checks that up-copy together with down-copy clears instead of doing a transfer, with and without the port load. A wrong priority would leave stale data in A or B. It also checks that the down-copy overrides a shift, and that the port load masks the port driver even when output is enabled. A broken decode would show as an extra shift or as a driven port during a load. A long mixed random run is compared against a behavioural model on every clock.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic [2:0] {
        A_HOLD, A_PORT, A_FROM_B, A_MERGE, A_ZERO
    } a_sel_e;

    typedef enum logic [1:0] {
        B_HOLD, B_FROM_A, B_SHIFT, B_ZERO
    } b_sel_e;

    typedef struct packed {
        a_sel_e a_sel;
        b_sel_e b_sel;
        logic   drive;
    } dr_op_t;

    // Active-low controls to one edge's operation set
    function automatic dr_op_t dr_decode_fn(input logic oe_n, input logic ld_n,
                                            input logic up_n, input logic dn_n,
                                            input logic sh_n);
        dr_op_t op;
        logic   clr;
        clr      = ~up_n & ~dn_n;
        op.drive = ~oe_n & ld_n;
        if (clr)
            op.a_sel = ld_n ? A_ZERO : A_PORT;
        else if (~up_n)
            op.a_sel = ld_n ? A_FROM_B : A_MERGE;
        else
            op.a_sel = ld_n ? A_HOLD : A_PORT;
        if (clr)
            op.b_sel = B_ZERO;
        else if (~dn_n)
            op.b_sel = B_FROM_A;
        else if (~sh_n)
            op.b_sel = B_SHIFT;
        else
            op.b_sel = B_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/dr_decode.sv
module dr_decode
    import dr_pkg::*;
(
    input  logic   oe_n,
    input  logic   ld_n,
    input  logic   up_n,
    input  logic   dn_n,
    input  logic   sh_n,
    output dr_op_t op
);
    always_comb op = dr_decode_fn(oe_n, ld_n, up_n, dn_n, sh_n);
endmodule

// File: rtl/dr_upper.sv
module dr_upper
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  a_sel_e           sel,
    input  logic [WIDTH-1:0] port_in,
    input  logic [WIDTH-1:0] b_val,
    output logic [WIDTH-1:0] a_q
);
    logic [WIDTH-1:0] merged;

    for (genvar i = 0; i < WIDTH; i++) begin : g_merge
        assign merged[i] = port_in[i] | b_val[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else begin
            unique case (sel)
                A_PORT:   a_q <= port_in;
                A_FROM_B: a_q <= b_val;
                A_MERGE:  a_q <= merged;
                A_ZERO:   a_q <= '0;
                default:  a_q <= a_q;
            endcase
        end
    end
endmodule

// File: rtl/dr_lower.sv
module dr_lower
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  b_sel_e           sel,
    input  logic [WIDTH-1:0] a_val,
    input  logic             ser_in,
    output logic [WIDTH-1:0] b_q,
    output logic             ser_out
);
    localparam int TOP = WIDTH - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else begin
            unique case (sel)
                B_FROM_A: b_q <= a_val;
                B_SHIFT:  b_q <= {b_q[TOP-1:0], ser_in};
                B_ZERO:   b_q <= '0;
                default:  b_q <= b_q;
            endcase
        end
    end

    assign ser_out = b_q[TOP];
endmodule

// File: rtl/dual_rank_shreg.sv
module dual_rank_shreg
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             ld_n,
    input  logic             up_n,
    input  logic             dn_n,
    input  logic             sh_n,
    input  logic [WIDTH-1:0] port_in,
    output logic [WIDTH-1:0] port_out,
    output logic             port_oe,
    input  logic             ser_in,
    output logic             ser_out
);
    dr_op_t           op;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;

    dr_decode u_dec (
        .oe_n(oe_n), .ld_n(ld_n), .up_n(up_n), .dn_n(dn_n), .sh_n(sh_n),
        .op(op)
    );

    dr_upper #(.WIDTH(WIDTH)) u_upper (
        .clk(clk), .rst(rst), .sel(op.a_sel),
        .port_in(port_in), .b_val(b_q), .a_q(a_q)
    );

    dr_lower #(.WIDTH(WIDTH)) u_lower (
        .clk(clk), .rst(rst), .sel(op.b_sel),
        .a_val(a_q), .ser_in(ser_in), .b_q(b_q), .ser_out(ser_out)
    );

    assign port_out = a_q;
    assign port_oe  = op.drive;
endmodule

// File: rtl/dual_rank_shreg_chk.sv
module dual_rank_shreg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             oe_n,
    input logic             ld_n,
    input logic             up_n,
    input logic             dn_n,
    input logic             sh_n,
    input logic [WIDTH-1:0] port_in,
    input logic [WIDTH-1:0] port_out,
    input logic             port_oe,
    input logic             ser_in,
    input logic [WIDTH-1:0] b_q
);
    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (port_out == '0 && b_q == '0)); // R1
    AST_LOAD_PORT: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && up_n) |=> port_out == $past(port_in)); // R2
    AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ld_n && up_n) |=> $stable(port_out)); // R3
    AST_DOWN_COPY: assert property (@(posedge clk) disable iff (rst)
        (!dn_n && up_n) |=> b_q == $past(port_out)); // R4
    AST_UP_COPY: assert property (@(posedge clk) disable iff (rst)
        (!up_n && dn_n && ld_n) |=> port_out == $past(b_q)); // R5
    AST_OR_MERGE: assert property (@(posedge clk) disable iff (rst)
        (!up_n && dn_n && !ld_n) |=> port_out == ($past(b_q) | $past(port_in))); // R6
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!sh_n && dn_n) |=> b_q == {$past(b_q[WIDTH-2:0]), $past(ser_in)}); // R7
    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (rst)
        (!up_n && !dn_n && ld_n) |=> (port_out == '0 && b_q == '0)); // R9
    AST_CLEAR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!up_n && !dn_n && !ld_n) |=> (port_out == $past(port_in) && b_q == '0)); // R10
    AST_LOAD_MASKS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !ld_n |-> !port_oe); // R12
    AST_DRIVE_WHEN_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && ld_n) |-> port_oe); // R12
endmodule

bind dual_rank_shreg dual_rank_shreg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .oe_n(oe_n), .ld_n(ld_n), .up_n(up_n),
    .dn_n(dn_n), .sh_n(sh_n), .port_in(port_in), .port_out(port_out),
    .port_oe(port_oe), .ser_in(ser_in), .b_q(b_q)
);

// File: tb/dual_rank_shreg_test.sv
module dual_rank_shreg_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         oe_n = 1'b1, ld_n = 1'b1, up_n = 1'b1, dn_n = 1'b1, sh_n = 1'b1;
    logic [W-1:0] port_in = '0;
    logic         ser_in = 1'b0;
    logic [W-1:0] port_out;
    logic         port_oe;
    logic         ser_out;

    int checks = 0;
    int fails  = 0;
    int ma = 0;  // model of upper rank
    int mb = 0;  // model of lower rank
    bit done = 0;

    always #10 clk = ~clk;

    dual_rank_shreg #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .oe_n(oe_n), .ld_n(ld_n), .up_n(up_n),
        .dn_n(dn_n), .sh_n(sh_n), .port_in(port_in), .port_out(port_out),
        .port_oe(port_oe), .ser_in(ser_in), .ser_out(ser_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one edge's controls, update the model, compare outputs
    task automatic step(input bit o, input bit l, input bit u, input bit d,
                        input bit s, input int pin, input bit sin, input string req);
        int na, nb;
        oe_n = o; ld_n = l; up_n = u; dn_n = d; sh_n = s;
        port_in = pin[W-1:0]; ser_in = sin;
        #2;
        chk({req, "/R12 port_oe"}, int'(port_oe), int'(!o && l));
        na = ma; nb = mb;
        if (!u && !d) begin
            na = l ? 0 : pin;
            nb = 0;
        end else begin
            if (!u) na = l ? mb : (pin | mb);
            else if (!l) na = pin;
            if (!d) nb = ma;
            else if (!s) nb = ((mb * 2) + sin) % 256;
        end
        @(posedge clk);
        ma = na; mb = nb;
        @(negedge clk);
        chk({req, " port_out"}, int'(port_out), ma);
        chk({req, "/R7 ser_out"}, int'(ser_out), (mb / 128) % 2);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset port_out", int'(port_out), 0);
        chk("R1 reset ser_out", int'(ser_out), 0);
        chk("R12 idle port_oe", int'(port_oe), 0);

        step(1, 0, 1, 1, 1, 'hA5, 0, "R2 load");
        step(0, 1, 1, 1, 1, 'h11, 1, "R3 hold");
        step(1, 0, 1, 0, 1, 'h3C, 0, "R8 load+down");   // A=3C, B=A5
        step(1, 1, 0, 1, 1, 'hFF, 0, "R5 up");          // A=A5
        step(1, 1, 1, 1, 0, 'h00, 1, "R7 shift1");
        step(1, 1, 1, 1, 0, 'h00, 0, "R7 shift0");
        step(0, 1, 1, 1, 0, 'h00, 1, "R7 shift1 oe");
        step(1, 1, 1, 0, 0, 'h00, 1, "R11 down over shift");
        step(1, 1, 1, 1, 1, 'h5A, 0, "R3 hold B");
        step(1, 1, 1, 0, 1, 'h00, 0, "R4 down");
        step(1, 0, 1, 1, 1, 'h0F, 0, "R2 load");
        step(1, 1, 1, 0, 1, 'h00, 0, "R4 down");        // B=0F
        step(1, 0, 1, 1, 1, 'h30, 0, "R2 load");        // A=30
        step(1, 0, 0, 1, 1, 'h40, 0, "R6 or merge");    // A=40|0F
        step(1, 1, 0, 1, 0, 'h00, 1, "R8 up+shift");
        step(1, 0, 1, 1, 0, 'hC3, 1, "R8 load+shift");
        step(1, 1, 0, 0, 0, 'hFF, 1, "R9 clear");
        step(1, 0, 1, 1, 1, 'h99, 0, "R2 load");
        step(1, 1, 1, 0, 1, 'h00, 0, "R4 down");
        step(1, 0, 0, 0, 1, 'h77, 0, "R10 clear+load");
        step(0, 0, 1, 1, 1, 'h81, 0, "R12 load masks drive");
        step(0, 1, 1, 0, 1, 'h00, 0, "R12 oe with down");
        step(0, 1, 0, 1, 0, 'h00, 1, "R12 oe with up+shift");
        for (int i = 0; i < 400; i++) begin
            step(bit'($urandom_range(1)), bit'($urandom_range(1)),
                 bit'($urandom_range(1)), bit'($urandom_range(1)),
                 bit'($urandom_range(1)), int'($urandom_range(255)),
                 bit'($urandom_range(1)), "R8 mixed");
        end
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ma = 0; mb = 0;
        chk("R1 re-reset port_out", int'(port_out), 0);
        chk("R1 re-reset ser_out", int'(ser_out), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule